// File: doc/BRIEF.md
# DMA Channel Hardware-Request Sequencer

This block is the control core of a single DMA channel that moves data on behalf of a peripheral. Software loads a beat count, a block count, a source and a destination address, then starts the channel. The channel moves into its running state and waits for the peripheral's request line. Each accepted request makes it issue single-beat bus requests. For every acknowledged beat it steps the addresses and counts down. When the last beat of the last block lands, it returns to the idle state and reports success.

Two request modes exist. In block mode, each rising edge of the request line buys one block of `cfg_beats+1` beats, and the channel waits in the running state for more edges until `cfg_blocks+1` blocks have moved. In burst mode, a single edge starts the whole `(cfg_beats+1)*(cfg_blocks+1)` transfer. The channel can be held by software, aborted by software, aborted by the peripheral's stop line, or stopped by a bus error. Each ending leaves a 3-bit stop code behind and, if enabled, raises a one-cycle interrupt. On success, counters and addresses can be restored from the values captured at start, so the channel is ready to run again.

Top module: `dmach_ctrl`

## Requirements
- R1: After reset the channel is idle (`ch_state` = 0), `stop_code` is 3'b000, and `bus_req`, `per_req_clr`, `irq_done` and `irq_fail` are all low.
- R2: While idle (`ch_state` = 0), request edges are ignored: no `per_req_clr` pulse and no `bus_req`. A one-cycle `sw_start` moves the channel to running (`ch_state` = 1) and loads the counters and addresses from the configuration inputs.
- R3: In block mode (`cfg_burst` = 0), a request rising edge seen while running with no block in progress is accepted. The channel pulses `per_req_clr` for one cycle, issues exactly `cfg_beats+1` beats, then stays running and waits for the next edge. A beat is a cycle with `bus_req` and `bus_ack` high and `bus_err`, `per_stop` and `sw_stop` low.
- R4: In block mode, a rising edge that arrives while a block is in progress adds no beats, but it is answered with a one-cycle `per_req_clr` pulse.
- R5: In burst mode (`cfg_burst` = 1), the first accepted edge starts all `(cfg_beats+1)*(cfg_blocks+1)` beats. Later edges add no beats and give no `per_req_clr`.
- R6: After the last beat of the last block, the channel goes idle with `stop_code` = 3'b101, and `irq_done` pulses for one cycle if `irq_en` is high.
- R7: On success, `beats_left`/`blocks_left` are restored to the values loaded at start if `cfg_reload_cnt` is set, and otherwise stay at 0. Each address is restored to its start value if its reload bit is set.
- R8: Each beat advances an address by `1 << cfg_size` bytes, unless that address's fixed bit is set. `bus_src` and `bus_dst` show the address for the current beat.
- R9: `per_stop` high while running sends the channel idle with `stop_code` = 3'b010, and `irq_fail` pulses if `irq_en` is high. Counters and addresses keep the values they had at that moment.
- R10: While `per_stop` is high, request edges are masked: an edge that arrives under the mask is never accepted later.
- R11: While held (`ch_state` = 2, entered by `sw_pause` high while running), `bus_req` stays low and no `per_req_clr` pulse is given. An edge seen while held with no block in progress is remembered and accepted once `sw_pause` falls and the channel is running again.
- R12: `sw_stop` high while running or held sends the channel idle with `stop_code` = 3'b010, and `irq_fail` pulses if `irq_en` is high.
- R13: A beat acknowledged with `bus_err` high sends the channel idle with `stop_code` = 3'b001, and `irq_fail` pulses if `irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Start pulse, taken while idle |
| sw_pause | input | 1 | Hold level |
| sw_stop | input | 1 | Software abort |
| irq_en | input | 1 | Interrupt enable |
| cfg_burst | input | 1 | 1 = burst mode, 0 = block mode |
| cfg_beats | input | CW | Beats per block minus one |
| cfg_blocks | input | CW | Blocks minus one |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_size | input | 2 | Log2 of the beat width in bytes |
| cfg_src_fixed | input | 1 | Source address does not step |
| cfg_dst_fixed | input | 1 | Destination address does not step |
| cfg_reload_cnt | input | 1 | Restore counts on success |
| cfg_reload_src | input | 1 | Restore source on success |
| cfg_reload_dst | input | 1 | Restore destination on success |
| per_req | input | 1 | Peripheral transfer request level |
| per_stop | input | 1 | Peripheral stop request level |
| per_req_clr | output | 1 | One-cycle request clear to peripheral |
| bus_req | output | 1 | Single-beat bus request |
| bus_src | output | AW | Source address of the current beat |
| bus_dst | output | AW | Destination address of the current beat |
| bus_ack | input | 1 | Beat acknowledge |
| bus_err | input | 1 | Beat error, valid with bus_ack |
| ch_state | output | 2 | 0 idle, 1 running, 2 held |
| stop_code | output | 3 | Result of the last run |
| irq_done | output | 1 | Success interrupt pulse |
| irq_fail | output | 1 | Failure interrupt pulse |
| beats_left | output | CW | Beats left in the block, minus one |
| blocks_left | output | CW | Blocks left, minus one |

## Verification
The assertions check, on every cycle, the properties that hold within one or two cycles: no bus request while idle or held, no request clear while idle, the stop code that goes with each interrupt, and the idle state and code that follow a peripheral stop or a bus error. What only the bench scenarios can show is the counting and the order of events over many cycles: the number of beats each request edge buys in block and burst mode, edges dropped mid-block, an edge remembered across a hold, an edge lost under the stop mask, and the restore-or-hold values once a run ends. For these, a behavioural reference model is compared with the outputs on every clock.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_RUN  = 2'd1,
    CH_HOLD = 2'd2
  } ch_state_e;

  localparam logic [2:0] CODE_CLEAR  = 3'b000;
  localparam logic [2:0] CODE_BUSERR = 3'b001;
  localparam logic [2:0] CODE_HALT   = 3'b010;
  localparam logic [2:0] CODE_DONE   = 3'b101;

  localparam int unsigned ADDR_CH = 2;  // source and destination

endpackage

// File: rtl/dmach_req_edge.sv
// Rising-edge detector for the peripheral request line with stop masking.
module dmach_req_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req_lvl,
  input  logic stop_lvl,
  output logic req_rise
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= req_lvl;
  end

  // masked while the stop line is high (R10)
  assign req_rise = req_lvl & ~prev_q & ~stop_lvl;

endmodule

// File: rtl/dmach_addr_step.sv
// One address walker: loads at start, steps per beat, restores on success.
module dmach_addr_step #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step_en,
  input  logic          restore,
  input  logic          reload_en,
  input  logic          fixed,
  input  logic [1:0]    size,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q, addr_n;
  logic [AW-1:0] home_q, home_n;
  logic [AW-1:0] stride;

  assign stride = {{(AW-1){1'b0}}, 1'b1} << size;

  always_comb begin
    addr_n = addr_q;
    home_n = home_q;
    if (load) begin
      addr_n = base;
      home_n = base;
    end else if (restore && reload_en) begin
      addr_n = home_q;
    end else if (step_en && !fixed) begin
      addr_n = addr_q + stride;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      home_q <= '0;
    end else begin
      addr_q <= addr_n;
      home_q <= home_n;
    end
  end

  assign addr = addr_q;

endmodule

// File: rtl/dmach_beat_count.sv
// Beat and block down-counters with start-time shadow copies.
module dmach_beat_count #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          beat,
  input  logic          restore,
  input  logic          reload_en,
  input  logic [CW-1:0] cfg_beats,
  input  logic [CW-1:0] cfg_blocks,
  output logic [CW-1:0] beats_left,
  output logic [CW-1:0] blocks_left,
  output logic          blk_last,
  output logic          all_last
);

  logic [CW-1:0] bc_q, bc_n, tc_q, tc_n;
  logic [CW-1:0] bc_home_q, bc_home_n, tc_home_q, tc_home_n;

  assign blk_last = (bc_q == '0);
  assign all_last = blk_last && (tc_q == '0);

  always_comb begin
    bc_n      = bc_q;
    tc_n      = tc_q;
    bc_home_n = bc_home_q;
    tc_home_n = tc_home_q;
    if (load) begin
      bc_n      = cfg_beats;
      tc_n      = cfg_blocks;
      bc_home_n = cfg_beats;
      tc_home_n = cfg_blocks;
    end else if (restore) begin
      if (reload_en) begin
        bc_n = bc_home_q;
        tc_n = tc_home_q;
      end
    end else if (beat) begin
      if (blk_last) begin
        bc_n = bc_home_q;
        tc_n = tc_q - 1'b1;
      end else begin
        bc_n = bc_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q      <= '0;
      tc_q      <= '0;
      bc_home_q <= '0;
      tc_home_q <= '0;
    end else begin
      bc_q      <= bc_n;
      tc_q      <= tc_n;
      bc_home_q <= bc_home_n;
      tc_home_q <= tc_home_n;
    end
  end

  assign beats_left  = bc_q;
  assign blocks_left = tc_q;

endmodule

// File: rtl/dmach_seq.sv
// Channel state machine: run/hold/idle, request acceptance, endings.
module dmach_seq
  import dmach_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_start,
  input  logic       sw_pause,
  input  logic       sw_stop,
  input  logic       irq_en,
  input  logic       burst,
  input  logic       per_stop,
  input  logic       req_rise,
  input  logic       bus_ack,
  input  logic       bus_err,
  input  logic       blk_last,
  input  logic       all_last,
  output ch_state_e  state,
  output logic       bus_req,
  output logic       load,
  output logic       beat,
  output logic       finish,
  output logic       req_clr,
  output logic       irq_done,
  output logic       irq_fail,
  output logic [2:0] code
);

  ch_state_e  state_q, state_n;
  logic       active_q, active_n;
  logic       pend_q, pend_n;
  logic [2:0] code_q, code_n;
  logic       clr_q, done_q, fail_q;

  logic in_run, in_hold, ack_ok;
  logic halt_sw, halt_per, halt_err, halt_any;
  logic accept, drop;

  assign in_run  = (state_q == CH_RUN);
  assign in_hold = (state_q == CH_HOLD);
  assign bus_req = in_run & active_q;
  assign ack_ok  = bus_req & bus_ack;

  assign halt_sw  = sw_stop & (in_run | in_hold);
  assign halt_per = in_run & per_stop & ~sw_stop;
  assign halt_err = in_run & ack_ok & bus_err & ~sw_stop & ~per_stop;
  assign halt_any = halt_sw | halt_per | halt_err;

  assign beat   = in_run & ack_ok & ~bus_err & ~sw_stop & ~per_stop;
  assign finish = beat & all_last;
  assign load   = (state_q == CH_OFF) & sw_start;

  assign accept = in_run & ~active_q & (pend_q | req_rise) & ~sw_stop & ~per_stop;
  assign drop   = in_run & active_q & ~burst & req_rise & ~sw_stop & ~per_stop
                & ~(ack_ok & bus_err);

  always_comb begin
    state_n = state_q;
    if (load)                      state_n = CH_RUN;
    else if (halt_any || finish)   state_n = CH_OFF;
    else if (in_run && sw_pause)   state_n = CH_HOLD;
    else if (in_hold && !sw_pause) state_n = CH_RUN;
  end

  always_comb begin
    active_n = active_q;
    if (load || halt_any || finish)   active_n = 1'b0;
    else if (accept)                  active_n = 1'b1;
    else if (beat && blk_last && !burst) active_n = 1'b0;
  end

  always_comb begin
    pend_n = pend_q;
    if (load || halt_any || accept) pend_n = 1'b0;
    else if (in_hold && !sw_stop && !active_q && req_rise) pend_n = 1'b1;
  end

  always_comb begin
    code_n = code_q;
    if (load)                      code_n = CODE_CLEAR;
    else if (halt_sw || halt_per)  code_n = CODE_HALT;
    else if (halt_err)             code_n = CODE_BUSERR;
    else if (finish)               code_n = CODE_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CH_OFF;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      code_q   <= CODE_CLEAR;
      clr_q    <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      active_q <= active_n;
      pend_q   <= pend_n;
      code_q   <= code_n;
      clr_q    <= accept | drop;
      done_q   <= finish & irq_en;
      fail_q   <= halt_any & irq_en;
    end
  end

  assign state    = state_q;
  assign req_clr  = clr_q;
  assign irq_done = done_q;
  assign irq_fail = fail_q;
  assign code     = code_q;

endmodule

// File: rtl/dmach_ctrl.sv
// Top: one DMA channel driven by a peripheral request line.
module dmach_ctrl
  import dmach_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_start,
  input  logic          sw_pause,
  input  logic          sw_stop,
  input  logic          irq_en,
  input  logic          cfg_burst,
  input  logic [CW-1:0] cfg_beats,
  input  logic [CW-1:0] cfg_blocks,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_src_fixed,
  input  logic          cfg_dst_fixed,
  input  logic          cfg_reload_cnt,
  input  logic          cfg_reload_src,
  input  logic          cfg_reload_dst,
  input  logic          per_req,
  input  logic          per_stop,
  output logic          per_req_clr,
  output logic          bus_req,
  output logic [AW-1:0] bus_src,
  output logic [AW-1:0] bus_dst,
  input  logic          bus_ack,
  input  logic          bus_err,
  output logic [1:0]    ch_state,
  output logic [2:0]    stop_code,
  output logic          irq_done,
  output logic          irq_fail,
  output logic [CW-1:0] beats_left,
  output logic [CW-1:0] blocks_left
);

  logic      req_rise, load, beat, finish, blk_last, all_last;
  ch_state_e st;

  logic [AW-1:0] base_v  [ADDR_CH];
  logic          fixed_v [ADDR_CH];
  logic          reload_v[ADDR_CH];
  logic [AW-1:0] addr_v  [ADDR_CH];

  assign base_v[0]   = cfg_src;
  assign base_v[1]   = cfg_dst;
  assign fixed_v[0]  = cfg_src_fixed;
  assign fixed_v[1]  = cfg_dst_fixed;
  assign reload_v[0] = cfg_reload_src;
  assign reload_v[1] = cfg_reload_dst;

  dmach_req_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_lvl  (per_req),
    .stop_lvl (per_stop),
    .req_rise (req_rise)
  );

  dmach_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_start (sw_start),
    .sw_pause (sw_pause),
    .sw_stop  (sw_stop),
    .irq_en   (irq_en),
    .burst    (cfg_burst),
    .per_stop (per_stop),
    .req_rise (req_rise),
    .bus_ack  (bus_ack),
    .bus_err  (bus_err),
    .blk_last (blk_last),
    .all_last (all_last),
    .state    (st),
    .bus_req  (bus_req),
    .load     (load),
    .beat     (beat),
    .finish   (finish),
    .req_clr  (per_req_clr),
    .irq_done (irq_done),
    .irq_fail (irq_fail),
    .code     (stop_code)
  );

  dmach_beat_count #(.CW(CW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .beat        (beat),
    .restore     (finish),
    .reload_en   (cfg_reload_cnt),
    .cfg_beats   (cfg_beats),
    .cfg_blocks  (cfg_blocks),
    .beats_left  (beats_left),
    .blocks_left (blocks_left),
    .blk_last    (blk_last),
    .all_last    (all_last)
  );

  for (genvar g = 0; g < ADDR_CH; g++) begin : g_addr
    dmach_addr_step #(.AW(AW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .step_en   (beat),
      .restore   (finish),
      .reload_en (reload_v[g]),
      .fixed     (fixed_v[g]),
      .size      (cfg_size),
      .base      (base_v[g]),
      .addr      (addr_v[g])
    );
  end

  assign bus_src  = addr_v[0];
  assign bus_dst  = addr_v[1];
  assign ch_state = st;

endmodule

// File: rtl/dmach_ctrl_chk.sv
// Assertion checker, bound to the channel top.
module dmach_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_stop,
  input logic       per_stop,
  input logic       per_req_clr,
  input logic       bus_req,
  input logic       bus_ack,
  input logic       bus_err,
  input logic [1:0] ch_state,
  input logic [2:0] stop_code,
  input logic       irq_done,
  input logic       irq_fail
);

  p_idle_no_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_state == 2'd0) |-> !bus_req);

  p_idle_no_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_state == 2'd0 && $past(ch_state == 2'd0)) |-> !per_req_clr);

  p_hold_no_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_state == 2'd2) |-> !bus_req);

  p_done_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (stop_code == 3'b101 && ch_state == 2'd0));

  p_fail_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fail |-> (stop_code == 3'b010 || stop_code == 3'b001));

  p_irq_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_done && irq_fail));

  p_per_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_state == 2'd1 && per_stop && !sw_stop)
      |=> (ch_state == 2'd0 && stop_code == 3'b010));

  p_bus_err_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_err && !sw_stop && !per_stop)
      |=> (ch_state == 2'd0 && stop_code == 3'b001));

endmodule

bind dmach_ctrl dmach_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_stop     (sw_stop),
  .per_stop    (per_stop),
  .per_req_clr (per_req_clr),
  .bus_req     (bus_req),
  .bus_ack     (bus_ack),
  .bus_err     (bus_err),
  .ch_state    (ch_state),
  .stop_code   (stop_code),
  .irq_done    (irq_done),
  .irq_fail    (irq_fail)
);

// File: tb/dmach_ctrl_test.sv
`timescale 1ns/1ps
module dmach_ctrl_test;

  localparam int AW = 32;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_start = 0, sw_pause = 0, sw_stop = 0, irq_en = 0, cfg_burst = 0;
  logic [CW-1:0] cfg_beats = 0, cfg_blocks = 0;
  logic [AW-1:0] cfg_src = 0, cfg_dst = 0;
  logic [1:0] cfg_size = 0;
  logic cfg_src_fixed = 0, cfg_dst_fixed = 0;
  logic cfg_reload_cnt = 0, cfg_reload_src = 0, cfg_reload_dst = 0;
  logic per_req = 0, per_stop = 0, bus_ack = 0, bus_err = 0;
  logic per_req_clr, bus_req, irq_done, irq_fail;
  logic [AW-1:0] bus_src, bus_dst;
  logic [1:0] ch_state;
  logic [2:0] stop_code;
  logic [CW-1:0] beats_left, blocks_left;

  always #10 clk = ~clk;  // 50 MHz

  dmach_ctrl #(.AW(AW), .CW(CW)) uut (.*);

  int n_run = 0, n_bad = 0;
  int n_beat = 0, n_clr = 0, n_done = 0, n_fail = 0;
  int ack_div = 1, ack_ctr = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st, m_bc, m_tc, m_bch, m_tch, m_code;
  logic [AW-1:0] m_src, m_dst, m_srch, m_dsth;
  bit m_prev, m_act, m_pend, m_clr, m_done, m_fail;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_bc = 0; m_tc = 0; m_bch = 0; m_tch = 0; m_code = 0;
      m_src = 0; m_dst = 0; m_srch = 0; m_dsth = 0;
      m_prev = 0; m_act = 0; m_pend = 0; m_clr = 0; m_done = 0; m_fail = 0;
    end else begin
      bit ack, rise, was_act, ended;
      int step;
      ack = (m_st == 1) && m_act && bus_ack;
      rise = per_req && !m_prev && !per_stop;
      m_prev = per_req;
      m_clr = 0; m_done = 0; m_fail = 0;
      was_act = m_act; ended = 0;
      step = 1 << cfg_size;
      if (m_st == 0) begin
        if (sw_start) begin
          m_st = 1; m_bc = cfg_beats; m_tc = cfg_blocks; m_bch = cfg_beats; m_tch = cfg_blocks;
          m_src = cfg_src; m_dst = cfg_dst; m_srch = cfg_src; m_dsth = cfg_dst;
          m_act = 0; m_pend = 0; m_code = 0;
        end
      end else if (sw_stop || (m_st == 1 && per_stop) || (ack && bus_err)) begin
        m_code = (sw_stop || per_stop) ? 2 : 1;
        m_st = 0; m_fail = irq_en; m_act = 0; m_pend = 0;
      end else if (m_st == 1) begin
        if (ack) begin
          if (m_bc == 0 && m_tc == 0) begin
            ended = 1; m_st = 0; m_code = 5; m_done = irq_en; m_act = 0; m_pend = 0;
            if (cfg_reload_cnt) begin m_bc = m_bch; m_tc = m_tch; end
            m_src = cfg_reload_src ? m_srch : (cfg_src_fixed ? m_src : m_src + step);
            m_dst = cfg_reload_dst ? m_dsth : (cfg_dst_fixed ? m_dst : m_dst + step);
          end else begin
            if (!cfg_src_fixed) m_src = m_src + step;
            if (!cfg_dst_fixed) m_dst = m_dst + step;
            if (m_bc == 0) begin
              m_bc = m_bch; m_tc = m_tc - 1;
              if (!cfg_burst) m_act = 0;
            end else m_bc = m_bc - 1;
          end
        end
        if (!was_act && (m_pend || rise)) begin m_act = 1; m_pend = 0; m_clr = 1; end
        else if (was_act && !cfg_burst && rise) m_clr = 1;
        if (!ended && sw_pause) m_st = 2;
      end else begin
        if (!m_act && rise) m_pend = 1;
        if (!sw_pause) m_st = 1;
      end
    end
  end

  // event counters (values of the cycle just closing)
  always @(posedge clk) if (rst_n) begin
    if (bus_req && bus_ack && !bus_err && !per_stop && !sw_stop) n_beat++;
    if (per_req_clr) n_clr++;
    if (irq_done) n_done++;
    if (irq_fail) n_fail++;
  end

  // compare on every clock, then drive the bus acknowledge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R12 state", 64'(ch_state), 64'(m_st));
      check("R6 stop_code", 64'(stop_code), 64'(m_code));
      check("R6 irq_done", 64'(irq_done), 64'(m_done));
      check("R9 irq_fail", 64'(irq_fail), 64'(m_fail));
      check("R4 per_req_clr", 64'(per_req_clr), 64'(m_clr));
      check("R11 bus_req", 64'(bus_req), 64'(m_st == 1 && m_act));
      check("R8 bus_src", 64'(bus_src), 64'(m_src));
      check("R8 bus_dst", 64'(bus_dst), 64'(m_dst));
      check("R7 beats_left", 64'(beats_left), 64'(m_bc));
      check("R7 blocks_left", 64'(blocks_left), 64'(m_tc));
    end
    bus_ack = bus_req && ((ack_ctr % ack_div) == 0);
    if (bus_req) ack_ctr++;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_req();
    per_req = 1; cyc(2); per_req = 0; cyc(2);
  endtask

  task automatic start();
    sw_start = 1; cyc(1); sw_start = 0; cyc(1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && ch_state != 2'd0; i++) @(negedge clk);
  endtask

  task automatic zero_counts();
    n_beat = 0; n_clr = 0; n_done = 0; n_fail = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    cyc(3);
    // R1: reset state
    check("R1 state", 64'(ch_state), 0);
    check("R1 stop_code", 64'(stop_code), 0);
    check("R1 outputs", 64'({bus_req, per_req_clr, irq_done, irq_fail}), 0);
    rst_n = 1;
    cyc(2);

    // R2: idle ignores requests
    zero_counts();
    pulse_req();
    check("R2 no clear while idle", 64'(n_clr), 0);
    check("R2 no bus while idle", 64'(bus_req), 0);

    // R3 R4 R6 R8: block mode, two blocks of three beats
    irq_en = 1; cfg_burst = 0; cfg_beats = 2; cfg_blocks = 1;
    cfg_src = 32'h1000; cfg_dst = 32'h2000; cfg_size = 2;
    cfg_src_fixed = 0; cfg_dst_fixed = 1; ack_div = 1;
    start();
    check("R2 start enters run", 64'(ch_state), 1);
    zero_counts();
    pulse_req(); cyc(8);
    check("R3 one block of beats", 64'(n_beat), 3);
    check("R3 waits in run", 64'(ch_state), 1);
    check("R3 one clear", 64'(n_clr), 1);
    ack_div = 3;
    pulse_req(); pulse_req();
    wait_idle(); cyc(1);
    check("R4 mid-block edge adds no beats", 64'(n_beat), 6);
    check("R4 mid-block edge cleared", 64'(n_clr), 3);
    check("R6 done code", 64'(stop_code), 3'b101);
    check("R6 done irq", 64'(n_done), 1);
    check("R8 src stepped by 4", 64'(bus_src), 32'h1018);
    check("R8 dst fixed", 64'(bus_dst), 32'h2000);
    check("R7 counts hold without reload", 64'({beats_left, blocks_left}), 0);

    // R5 R7: burst mode with reload
    cfg_burst = 1; cfg_beats = 1; cfg_blocks = 2; cfg_size = 0;
    cfg_dst_fixed = 0; cfg_reload_cnt = 1; cfg_reload_src = 1; cfg_reload_dst = 1;
    ack_div = 2;
    start(); zero_counts();
    pulse_req(); pulse_req();
    wait_idle(); cyc(1);
    check("R5 all beats from one edge", 64'(n_beat), 6);
    check("R5 only first edge cleared", 64'(n_clr), 1);
    check("R7 src restored", 64'(bus_src), 32'h1000);
    check("R7 dst restored", 64'(bus_dst), 32'h2000);
    check("R7 beats restored", 64'(beats_left), 1);
    check("R7 blocks restored", 64'(blocks_left), 2);

    // R9: peripheral stop mid-block
    cfg_burst = 0; cfg_beats = 3; cfg_blocks = 0; cfg_size = 2;
    cfg_reload_cnt = 0; cfg_reload_src = 0; cfg_reload_dst = 0;
    start(); zero_counts();
    per_req = 1;
    for (int i = 0; i < 50 && n_beat < 1; i++) @(negedge clk);
    per_stop = 1; cyc(1); per_stop = 0; per_req = 0; cyc(2);
    check("R9 idle after stop", 64'(ch_state), 0);
    check("R9 stop code", 64'(stop_code), 3'b010);
    check("R9 fail irq", 64'(n_fail), 1);
    check("R9 beats held", 64'(beats_left), 64'(3 - n_beat));
    check("R9 src held", 64'(bus_src), 64'(32'h1000 + 4 * n_beat));

    // R11: edge while held is remembered
    cfg_beats = 0; cfg_blocks = 1; ack_div = 1;
    start(); zero_counts();
    sw_pause = 1; cyc(2);
    pulse_req();
    check("R11 held state", 64'(ch_state), 2);
    check("R11 no clear while held", 64'(n_clr), 0);
    check("R11 no beats while held", 64'(n_beat), 0);
    sw_pause = 0; cyc(6);
    check("R11 pending edge accepted", 64'(n_clr), 1);
    check("R11 beat after release", 64'(n_beat), 1);

    // R10: edge under the stop mask is lost
    sw_pause = 1; cyc(2);
    per_stop = 1; cyc(1);
    pulse_req();
    per_stop = 0; cyc(1);
    sw_pause = 0; cyc(6);
    check("R10 masked edge not accepted", 64'(n_clr), 1);
    check("R10 no extra beat", 64'(n_beat), 1);
    check("R10 still running", 64'(ch_state), 1);

    // R12: software stop from held, then from running
    zero_counts();
    sw_pause = 1; cyc(2);
    sw_stop = 1; cyc(1); sw_stop = 0; sw_pause = 0; cyc(1);
    check("R12 stop from held", 64'({ch_state, stop_code}), {2'd0, 3'b010});
    start();
    sw_stop = 1; cyc(1); sw_stop = 0; cyc(1);
    check("R12 stop from run", 64'({ch_state, stop_code}), {2'd0, 3'b010});
    check("R12 fail irqs", 64'(n_fail), 2);

    // R13: bus error
    cfg_beats = 3; cfg_blocks = 0;
    start(); zero_counts();
    bus_err = 1;
    pulse_req(); cyc(2);
    bus_err = 0;
    check("R13 error code", 64'(stop_code), 3'b001);
    check("R13 idle", 64'(ch_state), 0);
    check("R13 fail irq", 64'(n_fail), 1);
    check("R13 no beats", 64'(n_beat), 0);

    cyc(4);
    summary();
  end

endmodule